// File: doc/BRIEF.md
# Dual-Source Interrupt Flag Hub

This block holds three interrupt flags that two motion-sensing submodules share: a three-channel input capture unit and a quadrature encoder front end. A mode select chooses which submodule is active. In capture mode each flag records a capture event on its own channel. In encoder mode the same three flags record a velocity register update, a position event and a direction reversal. The flags are sticky, so software clears them one bit at a time.

The hub also handles low-power sleep. While the sleep indicator is high, the encoder is halted, so its strobes are dropped. Capture events still set their flags. Any enabled pending flag then raises a wake request. The interrupt request is the OR of the enabled flags.

Top module: `evhub_irq_flags`

## Requirements
- R1: While `rst` is high at a rising clock edge, all flags are cleared. `irq` and `wake` are then low.
- R2: In capture mode (`mode_enc`=0), a high `cap_evt[i]` together with a high `cap_cfg[i]` sets `flags[i]` at the next rising edge. Bit 0 is channel 1, bit 1 is channel 2 and bit 2 is channel 3.
- R3: In capture mode, a capture event on a channel whose `cap_cfg` bit is low leaves that flag unchanged.
- R4: In encoder mode (`mode_enc`=1) and not asleep, `enc_vel` sets `flags[0]`, `enc_pos` sets `flags[1]` and `enc_dir` sets `flags[2]` at the next edge.
- R5: Strobes from the submodule that is not active do not change any flag.
- R6: In encoder mode with `sleep` high, encoder strobes set no flag.
- R7: In capture mode with `sleep` high, a configured capture event still sets its flag.
- R8: A flag stays set until a write with its `clr_flag` bit high. When a set event and a clear arrive in the same cycle, the flag ends up set.
- R9: `irq` is high in the same cycle exactly when some `flags[i]` and `irq_en[i]` are both high.
- R10: `wake` is high in the same cycle exactly when `sleep` is high and `irq` is high.
- R11: Changing `mode_enc` does not alter flags that are already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_enc | input | 1 | 0 selects capture, 1 selects encoder |
| sleep | input | 1 | Device is in low-power sleep |
| cap_evt | input | 3 | Capture event strobe per channel |
| cap_cfg | input | 3 | Channel set to an interrupting event type |
| enc_vel | input | 1 | Velocity register updated |
| enc_pos | input | 1 | Position measurement event |
| enc_dir | input | 1 | Direction change detected |
| irq_en | input | 3 | Per-flag interrupt enable |
| clr_flag | input | 3 | Per-flag clear write |
| flags | output | 3 | Sticky interrupt flags |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request |

## Verification
The bench targets several corner cases, each paired with the fault it would expose:

- **Set and clear in the same cycle.** A design that gives priority to the clear would lose an event.
- **Mode switch with flags pending.** A design that reset or remapped flags on a mode change would alter pending flags.
- **Sleep in each mode.** A block that gated capture during sleep would never wake, and one that did not gate the encoder would set phantom flags.
- **Strobes from the inactive source, and capture events on unconfigured channels.** Both must leave every flag untouched.

A behavioural model runs alongside the design and checks the flags, `irq` and `wake` on every cycle.

// File: rtl/evhub_pkg.sv
package evhub_pkg;
    localparam int NFLAG = 3;

    typedef logic [NFLAG-1:0] fvec_t;

    typedef enum logic {
        SRC_CAPTURE = 1'b0,
        SRC_ENCODER = 1'b1
    } src_e;

    typedef struct packed {
        logic dir;
        logic pos;
        logic vel;
    } enc_evt_t;

    // Encoder strobe to flag position: velocity->0, position->1, direction->2
    function automatic fvec_t enc_to_vec(enc_evt_t e);
        fvec_t v;
        v[0] = e.vel;
        v[1] = e.pos;
        v[2] = e.dir;
        return v;
    endfunction
endpackage

// File: rtl/evhub_select.sv
module evhub_select
    import evhub_pkg::*;
(
    input  src_e     mode,
    input  logic     sleep,
    input  fvec_t    cap_evt,
    input  fvec_t    cap_cfg,
    input  enc_evt_t enc,
    output fvec_t    set_vec
);
    fvec_t cap_set;
    fvec_t enc_set;

    always_comb begin
        cap_set = cap_evt & cap_cfg;
        enc_set = sleep ? '0 : enc_to_vec(enc);
        unique case (mode)
            SRC_CAPTURE: set_vec = cap_set;
            SRC_ENCODER: set_vec = enc_set;
            default:     set_vec = '0;
        endcase
    end
endmodule

// File: rtl/evhub_flagbank.sv
module evhub_flagbank
    import evhub_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  fvec_t set_vec,
    input  fvec_t clr_vec,
    output fvec_t q
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else if (set_vec[i])
                q[i] <= 1'b1;
            else if (clr_vec[i])
                q[i] <= 1'b0;
        end

        assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
            set_vec[i] |=> q[i]);
        assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
            (!set_vec[i] && clr_vec[i]) |=> !q[i]);
        assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
            (!set_vec[i] && !clr_vec[i]) |=> (q[i] == $past(q[i])));
    end
endmodule

// File: rtl/evhub_irq_flags.sv
module evhub_irq_flags
    import evhub_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_enc,
    input  logic       sleep,
    input  logic [2:0] cap_evt,
    input  logic [2:0] cap_cfg,
    input  logic       enc_vel,
    input  logic       enc_pos,
    input  logic       enc_dir,
    input  logic [2:0] irq_en,
    input  logic [2:0] clr_flag,
    output logic [2:0] flags,
    output logic       irq,
    output logic       wake
);
    src_e     mode;
    enc_evt_t enc;
    fvec_t    set_vec;
    fvec_t    q;

    assign mode = src_e'(mode_enc);
    assign enc  = '{dir: enc_dir, pos: enc_pos, vel: enc_vel};

    evhub_select u_sel (
        .mode    (mode),
        .sleep   (sleep),
        .cap_evt (cap_evt),
        .cap_cfg (cap_cfg),
        .enc     (enc),
        .set_vec (set_vec)
    );

    evhub_flagbank u_bank (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_flag),
        .q       (q)
    );

    assign flags = q;
    assign irq   = |(q & irq_en);
    assign wake  = sleep & irq;

    assert_enc_halt_R6: assert property (@(posedge clk) disable iff (rst)
        (sleep && mode_enc) |=> ((flags | $past(flags)) == $past(flags)));
    assert_sleep_capture_R7: assert property (@(posedge clk) disable iff (rst)
        (sleep && !mode_enc && cap_evt[1] && cap_cfg[1]) |=> flags[1]);
    assert_enc_map_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_enc && !sleep && enc_dir) |=> flags[2]);
    assert_cross_ignore_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_enc && clr_flag == 3'b000 && !enc_vel && !enc_pos && !enc_dir)
        |=> (flags == $past(flags)));
endmodule

// File: tb/evhub_irq_flags_test.sv
module evhub_irq_flags_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       mode_enc, sleep, enc_vel, enc_pos, enc_dir;
    logic [2:0] cap_evt, cap_cfg, irq_en, clr_flag;
    logic [2:0] flags;
    logic       irq, wake;

    int total = 0;
    int bad   = 0;
    bit mflag [3];

    always #4 clk = ~clk;

    evhub_irq_flags uut (
        .clk(clk), .rst(rst), .mode_enc(mode_enc), .sleep(sleep),
        .cap_evt(cap_evt), .cap_cfg(cap_cfg), .enc_vel(enc_vel),
        .enc_pos(enc_pos), .enc_dir(enc_dir), .irq_en(irq_en),
        .clr_flag(clr_flag), .flags(flags), .irq(irq), .wake(wake)
    );

    function automatic logic [2:0] model_vec();
        return {mflag[2], mflag[1], mflag[0]};
    endfunction

    task automatic compare(string tag);
        logic [2:0] ev;
        logic       ei, ew;
        ev = model_vec();
        ei = 1'b0;
        for (int i = 0; i < 3; i++) if (mflag[i] && irq_en[i]) ei = 1'b1;
        ew = sleep && ei;
        total += 3;
        if (flags !== ev) begin bad++; $display("FAIL %s flags actual=%b expected=%b", tag, flags, ev); end
        if (irq !== ei) begin bad++; $display("FAIL %s irq actual=%b expected=%b", tag, irq, ei); end
        if (wake !== ew) begin bad++; $display("FAIL %s wake actual=%b expected=%b", tag, wake, ew); end
    endtask

    // one cycle: inputs already set at negedge
    task automatic cyc(string tag);
        bit nxt [3];
        #1 compare(tag);
        for (int i = 0; i < 3; i++) begin
            bit s;
            s = 0;
            if (mode_enc) begin
                if (!sleep) s = (i == 0) ? enc_vel : (i == 1) ? enc_pos : enc_dir;
            end else begin
                s = cap_evt[i] && cap_cfg[i];
            end
            if (rst)              nxt[i] = 0;
            else if (s)           nxt[i] = 1;
            else if (clr_flag[i]) nxt[i] = 0;
            else                  nxt[i] = mflag[i];
        end
        @(posedge clk);
        mflag = nxt;
        @(negedge clk);
    endtask

    task automatic idle();
        cap_evt = 0; enc_vel = 0; enc_pos = 0; enc_dir = 0; clr_flag = 0;
    endtask

    initial begin
        #(200000 * 8);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        mflag = '{0, 0, 0};
        rst = 1; mode_enc = 0; sleep = 0; cap_cfg = 3'b111; irq_en = 3'b111;
        idle();
        cap_evt = 3'b111;
        @(negedge clk);
        cyc("R1"); cyc("R1");
        rst = 0; idle();
        cyc("R1");
        // capture mode
        cap_evt = 3'b101; cyc("R2"); idle(); cyc("R2");
        cap_cfg = 3'b000; cap_evt = 3'b010; cyc("R3"); idle(); cyc("R3");
        cap_cfg = 3'b111;
        enc_vel = 1; enc_pos = 1; enc_dir = 1; cyc("R5"); idle(); cyc("R5");
        clr_flag = 3'b001; cyc("R8"); idle(); cyc("R8");
        clr_flag = 3'b100; cap_evt = 3'b100; cyc("R8"); idle(); cyc("R8");
        // switch to encoder with a flag pending
        mode_enc = 1; cyc("R11"); cyc("R11");
        clr_flag = 3'b111; cyc("R8"); idle();
        enc_vel = 1; cyc("R4"); idle(); cyc("R4");
        clr_flag = 3'b111; cyc("R8"); idle();
        enc_pos = 1; cyc("R4"); idle(); cyc("R4");
        enc_dir = 1; cyc("R4"); idle(); cyc("R4");
        cap_evt = 3'b111; clr_flag = 3'b111; cyc("R5"); idle(); cyc("R5");
        // sleep, encoder halted
        sleep = 1;
        enc_vel = 1; enc_pos = 1; enc_dir = 1; cyc("R6"); cyc("R6"); idle(); cyc("R6");
        // sleep, capture still active
        mode_enc = 0; cyc("R11");
        irq_en = 3'b000; cap_evt = 3'b010; cyc("R7"); idle(); cyc("R10");
        irq_en = 3'b010; cyc("R10");
        irq_en = 3'b101; cyc("R10");
        sleep = 0; irq_en = 3'b010; cyc("R10");
        clr_flag = 3'b111; cyc("R8"); idle(); cyc("R9");
        // random traffic
        for (int n = 0; n < 600; n++) begin
            mode_enc = 1'($urandom); sleep = 1'(($urandom % 4) == 0);
            cap_evt = 3'($urandom); cap_cfg = 3'($urandom);
            enc_vel = 1'($urandom); enc_pos = 1'($urandom); enc_dir = 1'($urandom);
            irq_en = 3'($urandom); clr_flag = 3'($urandom);
            cyc("R9");
        end
        idle(); cyc("R9");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule